// File: doc/BRIEF.md
# Five-Source Interrupt Controller with Stack Gating

This block collects interrupt requests from five sources: an external pin event, two timer/event counters, an A/D conversion-complete event and an I2C bus event. Every source owns a request flag and an enable bit. These bits sit in two control registers, together with a single master enable. The block picks the highest-priority request that is ready. It then gives the sequencer a one-cycle take strobe and the vector address of the chosen source.

Accepting a request clears the master enable on its own. After that, no further interrupt can be accepted until software sets the master enable again. A service routine that wants nesting does exactly that. Requests keep latching while interrupts are blocked. A stack-full input from the sequencer holds off acceptance, even for a fully enabled request, until the stack has room again.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00 and `take` is low.
- R2: A one-cycle pulse on `src_evt[i]` sets the flag of source i at the next clock edge, whatever the enable and master-enable settings are.
- R3: `take` rises in the cycle after one in which the master enable, the enable of some source and the flag of that source are all 1 and `stack_full` is 0. `take` never rises in any other case, and it is high for a single cycle.
- R4: When several sources are ready, the one with the lowest index wins. The order from highest to lowest is external (0), timer 0 (1), timer 1 (2), A/D (3), I2C (4).
- R5: While `take` is high, `vector` holds 4*(i+1) for the winning source i: 0x04, 0x08, 0x0C, 0x10 or 0x14.
- R6: In the cycle `take` is high, the winner's flag and the master enable already read 0. The flags of the other sources are left unchanged.
- R7: While `stack_full` is 1, no request is taken. The pending flag stays set, and it is taken in the cycle after `stack_full` returns to 0.
- R8: If software sets the master enable again after a take, the next ready request is taken. This allows nested service.
- R9: Control register A (address 0) holds bit 0 = master enable, bits 1..3 = enables of sources 0..2, and bits 4..6 = flags of sources 0..2. Control register B (address 1) holds bits 0..1 = enables of sources 3..4 and bits 4..5 = flags of sources 3..4. Writes set every mapped bit. Unmapped bits and other addresses read 0.
- R10: An event on a source arriving in the same cycle as that source's take keeps its flag set. Event set wins over take clear, and take clear wins over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | Per-source event pulses, index 0 = external |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| stack_full | input | 1 | Return stack full; holds off acceptance |
| take | output | 1 | One-cycle interrupt-accept strobe |
| vector | output | 8 | Vector address of the accepted source, valid with take |

## Verification
Suppose a flag or enable is lost or stuck. The error shows in the very next read of the control register, and a take either never comes or fires one cycle after the wrong condition. A master enable that fails to clear shows up as a second take strobe on the cycle right after the first one. A broken priority mask gives the wrong vector in the same cycle as the strobe. The directed scenarios therefore line up every register read and strobe check on exact cycles, so that any of these faults shows within one or two clocks of its cause.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DATA_W = 8;
   typedef logic [DATA_W-1:0] reg_t;
   // fixed field offsets inside the control register images
   localparam int EN_OFS_A   = 1;
   localparam int FLAG_OFS   = 4;
   localparam int MAX_PER_A  = 3;
   localparam int MAX_PER_B  = 4;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
   import irq_pkg::*;
#(
   parameter int N_SRC  = 5,
   parameter int SPLIT  = 3,
   parameter int ADDR_W = 2,
   parameter logic [ADDR_W-1:0] ADDR_A = '0,
   parameter logic [ADDR_W-1:0] ADDR_B = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  reg_t              wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              take_fire,
   input  logic [N_SRC-1:0]  take_clr,
   output logic              emi,
   output logic [N_SRC-1:0]  en,
   output logic [N_SRC-1:0]  flag,
   output reg_t              rd_data
);
   logic wr_a, wr_b;
   reg_t img_a, img_b;
   reg_t part_a [N_SRC];
   reg_t part_b [N_SRC];
   logic unused_wr_bits;

   assign wr_a = wr_en && (wr_addr == ADDR_A);
   assign wr_b = wr_en && (wr_addr == ADDR_B);
   assign unused_wr_bits = ^wr_data;

   // master enable: a take clears it and beats a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         emi <= 1'b0;
      else if (take_fire) emi <= 1'b0;
      else if (wr_a)      emi <= wr_data[0];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam bit IN_A = (i < SPLIT);
      localparam int EB   = IN_A ? (EN_OFS_A + i) : (i - SPLIT);
      localparam int FB   = IN_A ? (FLAG_OFS + i) : (FLAG_OFS + i - SPLIT);
      logic wr_here;
      if (IN_A) begin : g_a
         assign wr_here = wr_a;
         assign part_a[i] = (reg_t'(en[i]) << EB) | (reg_t'(flag[i]) << FB);
         assign part_b[i] = '0;
      end else begin : g_b
         assign wr_here = wr_b;
         assign part_a[i] = '0;
         assign part_b[i] = (reg_t'(en[i]) << EB) | (reg_t'(flag[i]) << FB);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en[i] <= 1'b0;
         else if (wr_here) en[i] <= wr_data[EB];
      end

      // event set > take clear > register write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           flag[i] <= 1'b0;
         else if (evt[i])      flag[i] <= 1'b1;
         else if (take_clr[i]) flag[i] <= 1'b0;
         else if (wr_here)     flag[i] <= wr_data[FB];
      end
   end

   always_comb begin
      img_a = reg_t'(emi);
      img_b = '0;
      for (int i = 0; i < N_SRC; i++) begin
         img_a = img_a | part_a[i];
         img_b = img_b | part_b[i];
      end
      if (rd_addr == ADDR_A)      rd_data = img_a;
      else if (rd_addr == ADDR_B) rd_data = img_b;
      else                        rd_data = '0;
   end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int N     = 5,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   for (genvar i = 0; i < N; i++) begin : g_lvl
      localparam logic [N-1:0] LOWER = N'((64'd1 << i) - 64'd1);
      assign grant[i] = req[i] & ~|(req & LOWER);
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (grant[i]) idx = IDX_W'(i);
   end
endmodule

// File: rtl/irq_take.sv
module irq_take #(
   parameter int N        = 5,
   parameter int IDX_W    = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any,
   input  logic [IDX_W-1:0] idx,
   input  logic             stack_full,
   output logic             fire,
   output logic             take_q,
   output logic [VEC_W-1:0] vector_q
);
   logic [VEC_W-1:0] vec_next;

   assign fire     = any & ~stack_full;
   assign vec_next = VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q   <= 1'b0;
         vector_q <= '0;
      end else begin
         take_q <= fire;
         if (fire) vector_q <= vec_next;
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_pkg::*;
#(
   parameter int N_SRC    = 5,
   parameter int SPLIT    = 3,
   parameter int ADDR_W   = 2,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              stack_full,
   output logic              take,
   output logic [VEC_W-1:0]  vector
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (SPLIT > MAX_PER_A || SPLIT < 0) begin : g_bad_split
      $error("irq_ctrl: SPLIT out of range");
   end
   if (N_SRC - SPLIT > MAX_PER_B || N_SRC < 1) begin : g_bad_nsrc
      $error("irq_ctrl: N_SRC does not fit the two registers");
   end
   if (VEC_BASE + (N_SRC - 1) * VEC_STEP >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_ctrl: vector range exceeds VEC_W");
   end

   logic              emi_q;
   logic [N_SRC-1:0]  en_q, flag_q, ready, grant, clr;
   logic [IDX_W-1:0]  win_idx;
   logic              any_ready, fire;

   assign ready = flag_q & en_q & {N_SRC{emi_q}};
   assign clr   = grant & {N_SRC{fire}};

   irq_regs #(
      .N_SRC(N_SRC), .SPLIT(SPLIT), .ADDR_W(ADDR_W),
      .ADDR_A(ADDR_W'(0)), .ADDR_B(ADDR_W'(1))
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .evt(src_evt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .take_fire(fire), .take_clr(clr),
      .emi(emi_q), .en(en_q), .flag(flag_q), .rd_data(rd_data)
   );

   irq_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
      .req(ready), .grant(grant), .idx(win_idx), .any(any_ready)
   );

   irq_take #(
      .N(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
      .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_take (
      .clk(clk), .rst_n(rst_n), .any(any_ready), .idx(win_idx),
      .stack_full(stack_full), .fire(fire),
      .take_q(take), .vector_q(vector)
   );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int N_SRC    = 5,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] evt,
   input logic             stack_full,
   input logic             take,
   input logic [VEC_W-1:0] vector,
   input logic             emi,
   input logic [N_SRC-1:0] en,
   input logic [N_SRC-1:0] flag
);
   logic [N_SRC-1:0] rdy;
   assign rdy = flag & en & {N_SRC{emi}};

   assert_take_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ($past(emi) && ($past(rdy) != '0)));
   assert_take_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
   assert_emi_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !emi);
   assert_hold_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !$past(stack_full));

   for (genvar i = 0; i < N_SRC; i++) begin : g_chk
      localparam logic [VEC_W-1:0]  VEC_I = VEC_W'(VEC_BASE + i * VEC_STEP);
      localparam logic [N_SRC-1:0]  LOWER = N_SRC'((64'd1 << i) - 64'd1);
      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $past(evt[i]) |-> flag[i]);
      assert_prio_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (take && vector == VEC_I) |-> (($past(rdy) & LOWER) == '0) && $past(rdy[i]));
      assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (take && vector == VEC_I && !$past(evt[i])) |-> !flag[i]);
   end
endmodule

bind irq_ctrl irq_ctrl_chk #(
   .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt(src_evt), .stack_full(stack_full),
   .take(take), .vector(vector), .emi(emi_q), .en(en_q), .flag(flag_q)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] src_evt = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       stack_full = 1'b0;
   logic       take;
   logic [7:0] vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .stack_full(stack_full), .take(take), .vector(vector)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic pulse(logic [4:0] m);
      src_evt = m;
      @(negedge clk);
      src_evt = '0;
   endtask

   task automatic expect_take(string tag, logic [7:0] vec);
      chk({tag, " take"}, {7'd0, take}, 8'd1);
      chk({tag, " vector"}, vector, vec);
   endtask

   task automatic clear_all();
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_reset();
      rd("R1 regA", 2'd0, 8'h00);
      rd("R1 regB", 2'd1, 8'h00);
      chk("R1 take", {7'd0, take}, 8'd0);
   endtask

   task automatic t_latch();
      pulse(5'b11111);
      rd("R2 regA flags", 2'd0, 8'h70);
      rd("R2 regB flags", 2'd1, 8'h30);
      repeat (2) @(negedge clk);
      chk("R3 no take when disabled", {7'd0, take}, 8'd0);
      clear_all();
      rd("R9 regA cleared", 2'd0, 8'h00);
   endtask

   task automatic t_layout();
      wr(2'd0, 8'h8E);
      rd("R9 regA unused bit7", 2'd0, 8'h0E);
      wr(2'd1, 8'hCC);
      rd("R9 regB unused bits", 2'd1, 8'h00);
      wr(2'd2, 8'hFF);
      rd("R9 other address", 2'd2, 8'h00);
      rd("R9 regA kept", 2'd0, 8'h0E);
      clear_all();
   endtask

   task automatic t_masked();
      wr(2'd0, 8'h11);
      @(negedge clk);
      chk("R3 flag without enable", {7'd0, take}, 8'd0);
      wr(2'd1, 8'h12);
      @(negedge clk);
      chk("R3 enable on other source", {7'd0, take}, 8'd0);
      wr(2'd0, 8'h10);
      wr(2'd1, 8'h13);
      @(negedge clk);
      chk("R3 no master enable", {7'd0, take}, 8'd0);
      clear_all();
   endtask

   task automatic t_single();
      wr(2'd0, 8'h08);
      pulse(5'b00100);
      rd("R2 flag t1", 2'd0, 8'h48);
      wr(2'd0, 8'h49);
      chk("R3 take not yet", {7'd0, take}, 8'd0);
      @(negedge clk);
      expect_take("R5 timer1", 8'h0C);
      rd("R6 flag and master cleared", 2'd0, 8'h08);
      @(negedge clk);
      chk("R3 single-cycle strobe", {7'd0, take}, 8'd0);
      clear_all();
   endtask

   task automatic t_prio();
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h0E);
      pulse(5'b11111);
      wr(2'd0, 8'h7F);
      @(negedge clk);
      expect_take("R4 external first", 8'h04);
      rd("R6 others untouched", 2'd0, 8'h6E);
      @(negedge clk);
      chk("R6 no retake without master", {7'd0, take}, 8'd0);
      wr(2'd0, 8'h6F);
      @(negedge clk);
      expect_take("R8 nested timer0", 8'h08);
      wr(2'd0, 8'h4F);
      @(negedge clk);
      expect_take("R8 nested timer1", 8'h0C);
      wr(2'd0, 8'h0F);
      @(negedge clk);
      expect_take("R4 A/D before I2C", 8'h10);
      rd("R6 regB after A/D", 2'd1, 8'h23);
      wr(2'd0, 8'h0F);
      @(negedge clk);
      expect_take("R5 I2C", 8'h14);
      rd("R6 regB empty", 2'd1, 8'h03);
      clear_all();
   endtask

   task automatic t_stack();
      stack_full = 1'b1;
      wr(2'd0, 8'h13);
      for (int k = 0; k < 4; k++) begin
         chk("R7 held while full", {7'd0, take}, 8'd0);
         @(negedge clk);
      end
      rd("R7 still pending", 2'd0, 8'h13);
      stack_full = 1'b0;
      @(negedge clk);
      expect_take("R7 released", 8'h04);
      clear_all();
   endtask

   task automatic t_collide();
      wr(2'd0, 8'h13);
      src_evt = 5'b00001;
      @(negedge clk);
      src_evt = '0;
      expect_take("R10 collide", 8'h04);
      rd("R10 flag kept by event", 2'd0, 8'h12);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_layout();
      t_masked();
      t_single();
      t_prio();
      t_stack();
      t_collide();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule